// File: doc/BRIEF.md
# UART Buffer Status Flags

This block holds the transmit and receive byte buffers of a serial port and reports their state in a 32-bit read-only status word. A mode input picks how much storage each direction uses. With the mode input high, each direction is a multi-entry first-in first-out queue. With it low, each direction is a single holding register. The empty and full flags follow whichever depth is currently selected.

A busy flag follows transmitter activity. It rises as soon as the transmit buffer holds a byte, and no enable gates it. It stays high while the transmit shifter is working. It drops only after the shifter reports that the last stop bit of its character has gone out and the buffer is empty.

All four data edges use valid/ready handshakes. A byte moves on a rising clock edge when valid and ready are both high. A writer whose ready is low must hold its byte and try again; nothing is stored for it. The transmit output feeds the shift register, and each accepted transfer there starts one character. The bit shifter, baud timing and interrupts are outside this block.

Top module: `uart_buf_flags`

## Requirements
- R1: Status word layout: bit 7 = transmit empty, bit 6 = receive full, bit 5 = transmit full, bit 4 = receive empty, bit 3 = busy; every other bit reads 0.
- R2: Out of reset the status word is 0x00000090, the held output bytes are 0, the shifter is idle, and the stored previous mode value is 0 (holding mode).
- R3: With `fifo_en` high, each buffer takes up to DEPTH bytes (default 16) and returns them in arrival order. Full is reported at DEPTH entries and empty at zero entries.
- R4: With `fifo_en` low, each buffer holds at most one byte. Full is reported at one entry.
- R5: A full buffer drives its input ready low. An offered byte is then neither stored nor counted, and the buffer's contents and flags do not change.
- R6: An empty buffer drives its output valid low. An output ready is then ignored, and the output data keeps showing the last byte handed out (0 if none).
- R7: In any cycle where `fifo_en` differs from its value on the previous clock edge, all four handshakes are refused and both buffers are empty from the next cycle on.
- R8: Busy is high whenever the transmit buffer is not empty, with no enable condition.
- R9: A transfer on the transmit output marks the shifter active. A `shift_done` pulse clears it one cycle later unless a new transfer occurs in that same cycle. Busy is high while the shifter is active.
- R10: A write and a read on the same buffer in one cycle both take effect, with ready and valid judged on the occupancy before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = multi-entry queues, 0 = single holding registers |
| tx_in_valid | input | 1 | Host offers a byte for transmission |
| tx_in_ready | output | 1 | Transmit buffer can take a byte |
| tx_in_data | input | DW | Byte to transmit |
| tx_out_valid | output | 1 | Transmit buffer has a byte for the shifter |
| tx_out_ready | input | 1 | Shifter takes the byte and starts a character |
| tx_out_data | output | DW | Head byte, or last byte handed out when empty |
| shift_done | input | 1 | Pulse: last stop bit of the current character has left the shifter |
| rx_in_valid | input | 1 | Receiver offers a byte |
| rx_in_ready | output | 1 | Receive buffer can take a byte |
| rx_in_data | input | DW | Received byte |
| rx_out_valid | output | 1 | Receive buffer has a byte for the host |
| rx_out_ready | input | 1 | Host takes the byte |
| rx_out_data | output | DW | Head byte, or last byte handed out when empty |
| flag_word | output | 32 | Status word |

## Verification
Two kinds of events can fall in one cycle. A write and a read can hit the same buffer in the same cycle, and a new transmit transfer can coincide with the `shift_done` pulse of the previous character. The bench provokes the first with long runs of random valid and ready patterns at every fill level, including full and empty. It provokes the second by pulsing `shift_done` in the very cycle a queued byte moves to the shifter. A queue-based reference model predicts every ready, valid, data byte and status bit for each cycle, and the bench compares all of them on every clock. In the coincident-load case the busy flag must not drop.

// File: rtl/ufl_pkg.sv
package ufl_pkg;
  localparam int FLAG_W      = 32;
  localparam int BIT_TX_EMPT = 7;
  localparam int BIT_RX_FULL = 6;
  localparam int BIT_TX_FULL = 5;
  localparam int BIT_RX_EMPT = 4;
  localparam int BIT_BUSY    = 3;

  typedef struct packed {
    logic tx_empty;
    logic tx_full;
    logic rx_empty;
    logic rx_full;
    logic busy;
  } flag_set_t;

  function automatic logic [FLAG_W-1:0] pack_flags(input flag_set_t f);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[BIT_TX_EMPT] = f.tx_empty;
    w[BIT_RX_FULL] = f.rx_full;
    w[BIT_TX_FULL] = f.tx_full;
    w[BIT_RX_EMPT] = f.rx_empty;
    w[BIT_BUSY]    = f.busy;
    return w;
  endfunction
endpackage

// File: rtl/ufl_buf.sv
module ufl_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          is_empty,
  output logic          is_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_q, rd_q, cnt, lim;
  logic [DW-1:0] last_q;
  logic          push, pop;

  assign lim       = fifo_en ? CW'(DEPTH) : CW'(1);
  assign cnt       = wr_q - rd_q;
  assign is_empty  = (cnt == '0);
  assign is_full   = (cnt == lim);
  assign in_ready  = !flush && !is_full;
  assign out_valid = !flush && !is_empty;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = is_empty ? last_q : mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      last_q <= '0;
    end else if (flush) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + CW'(1);
      if (pop) begin
        rd_q   <= rd_q + CW'(1);
        last_q <= mem[rd_q[AW-1:0]];
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4
  holding_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flush) |-> (cnt <= CW'(1)));
  // R5
  full_push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_full && !flush) |=> $stable(wr_q));
  // R6
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && is_empty && !flush) |=> ($stable(rd_q) && $stable(last_q)));
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> is_empty);
endmodule

// File: rtl/ufl_busy.sv
module ufl_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift_done,
  input  logic tx_nonempty,
  output logic busy
);
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          active_q <= 1'b0;
    else if (load)       active_q <= 1'b1;
    else if (shift_done) active_q <= 1'b0;
  end

  assign busy = tx_nonempty || active_q;

  // R8
  busy_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nonempty |-> busy);
  // R9
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  // R9
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && !load) |=> !active_q);
endmodule

// File: rtl/uart_buf_flags.sv
module uart_buf_flags #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          shift_done,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic [31:0]   flag_word
);
  import ufl_pkg::*;

  logic      mode_q, flush;
  logic      tx_empty, tx_full, rx_empty, rx_full, busy;
  flag_set_t fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end
  assign flush = (fifo_en != mode_q);

  ufl_buf #(.DEPTH(DEPTH), .DW(DW)) tx_buf_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .is_empty(tx_empty), .is_full(tx_full)
  );

  ufl_buf #(.DEPTH(DEPTH), .DW(DW)) rx_buf_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .is_empty(rx_empty), .is_full(rx_full)
  );

  ufl_busy busy_i (
    .clk(clk), .rst_n(rst_n),
    .load(tx_out_valid && tx_out_ready),
    .shift_done(shift_done),
    .tx_nonempty(!tx_empty),
    .busy(busy)
  );

  always_comb begin
    fs.tx_empty = tx_empty;
    fs.tx_full  = tx_full;
    fs.rx_empty = rx_empty;
    fs.rx_full  = rx_full;
    fs.busy     = busy;
  end
  assign flag_word = pack_flags(fs);

  // R7
  mode_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(tx_in_ready || tx_out_valid || rx_in_ready || rx_out_valid));
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_word[31:8] == '0) && (flag_word[2:0] == '0));
endmodule

// File: tb/uart_buf_flags_tb.sv
`timescale 1ns/1ps
module uart_buf_flags_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, fifo_en, shift_done;
  logic tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
  logic [7:0] tx_in_data, tx_out_data, rx_in_data, rx_out_data;
  logic [31:0] flag_word;

  uart_buf_flags #(.DEPTH(16), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .shift_done(shift_done),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .flag_word(flag_word)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R2";
  logic [7:0] tq[$], rq[$];
  logic [7:0] last_t = 8'h00, last_r = 8'h00;
  bit act = 0, mode_q = 0;

  task automatic chk(input logic [31:0] a, input logic [31:0] e, input string what);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, a, e);
    end
  endtask

  // One clock: compare all outputs against the model, then advance the model.
  task automatic step();
    int lim;
    bit mchg, e_tir, e_tov, e_rir, e_rov, bsy;
    logic [7:0] e_tod, e_rod;
    logic [31:0] e_fl;
    #1;
    mchg  = (fifo_en != mode_q);
    lim   = fifo_en ? 16 : 1;
    e_tir = !mchg && (tq.size() < lim);
    e_tov = !mchg && (tq.size() > 0);
    e_rir = !mchg && (rq.size() < lim);
    e_rov = !mchg && (rq.size() > 0);
    e_tod = (tq.size() > 0) ? tq[0] : last_t;
    e_rod = (rq.size() > 0) ? rq[0] : last_r;
    bsy   = (tq.size() > 0) || act;
    e_fl  = 32'h0;
    e_fl[7] = (tq.size() == 0);
    e_fl[6] = (rq.size() == lim);
    e_fl[5] = (tq.size() == lim);
    e_fl[4] = (rq.size() == 0);
    e_fl[3] = bsy;
    chk(flag_word, e_fl, "flag_word");
    chk({31'b0, tx_in_ready}, {31'b0, e_tir}, "tx_in_ready");
    chk({31'b0, tx_out_valid}, {31'b0, e_tov}, "tx_out_valid");
    chk({31'b0, rx_in_ready}, {31'b0, e_rir}, "rx_in_ready");
    chk({31'b0, rx_out_valid}, {31'b0, e_rov}, "rx_out_valid");
    chk({24'b0, tx_out_data}, {24'b0, e_tod}, "tx_out_data");
    chk({24'b0, rx_out_data}, {24'b0, e_rod}, "rx_out_data");
    @(posedge clk);
    if (mchg) begin
      tq.delete();
      rq.delete();
    end else begin
      if (e_tov && tx_out_ready) last_t = tq.pop_front();
      if (e_tir && tx_in_valid) tq.push_back(tx_in_data);
      if (e_rov && rx_out_ready) last_r = rq.pop_front();
      if (e_rir && rx_in_valid) rq.push_back(rx_in_data);
    end
    if (e_tov && tx_out_ready) act = 1;
    else if (shift_done) act = 0;
    mode_q = fifo_en;
    @(negedge clk);
  endtask

  task automatic idle_in();
    tx_in_valid = 0; tx_out_ready = 0; rx_in_valid = 0; rx_out_ready = 0;
    shift_done = 0;
  endtask

  task automatic rand_cycle();
    tx_in_valid  = $urandom_range(0, 1);
    tx_in_data   = 8'($urandom);
    tx_out_ready = ($urandom_range(0, 2) == 0);
    rx_in_valid  = $urandom_range(0, 1);
    rx_in_data   = 8'($urandom);
    rx_out_ready = ($urandom_range(0, 2) == 0);
    shift_done   = ($urandom_range(0, 7) == 0);
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fifo_en = 0; tx_in_data = 0; rx_in_data = 0;
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R2 reset state
    tag = "R2";
    #1 chk(flag_word, 32'h0000_0090, "reset flag_word");
    @(negedge clk);
    step();

    // R7 switch into queue mode, then R3 fill both queues
    fifo_en = 1; tag = "R7"; step();
    tag = "R3";
    for (int i = 0; i < 18; i++) begin
      if (i >= 16) tag = "R5";
      tx_in_valid = 1; tx_in_data = 8'(i + 1);
      rx_in_valid = 1; rx_in_data = 8'(8'h40 + i);
      step();
    end
    idle_in();
    // R1 layout: both full, busy, nothing empty -> 0x68
    tag = "R1";
    #1 chk(flag_word, 32'h0000_0068, "full flag_word");
    @(negedge clk);
    tag = "R3";
    tx_out_ready = 1; rx_out_ready = 1;
    for (int i = 0; i < 16; i++) step();
    tag = "R6";
    for (int i = 0; i < 3; i++) step();
    #1;
    chk({24'b0, tx_out_data}, 32'd16, "tx held byte");
    chk({24'b0, rx_out_data}, 32'h4f, "rx held byte");
    @(negedge clk);
    idle_in();

    // R10 mixed traffic, concurrent writes and reads
    tag = "R10";
    for (int i = 0; i < 600; i++) rand_cycle();

    // R7 change mode with data queued
    idle_in();
    tag = "R7";
    tx_in_valid = 1; rx_in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      tx_in_data = 8'(8'h80 + i); rx_in_data = 8'(8'hc0 + i); step();
    end
    idle_in();
    fifo_en = 0; step();
    #1 chk({30'b0, flag_word[7], flag_word[4]}, 32'd3, "both empty after flush");
    @(negedge clk);

    // R4 holding-register mode
    tag = "R4";
    for (int i = 0; i < 400; i++) rand_cycle();
    for (int i = 0; i < 8; i++) begin
      fifo_en = i[0]; tag = "R7"; rand_cycle();
    end
    fifo_en = 1; tag = "R7"; step();

    // R8 / R9 busy sequencing
    idle_in();
    tag = "R9";
    tx_out_ready = 1; shift_done = 1;
    for (int i = 0; i < 20; i++) step();
    idle_in(); step();
    tag = "R8";
    tx_in_valid = 1; tx_in_data = 8'h55; step();
    tx_in_valid = 1; tx_in_data = 8'h66; step();
    idle_in();
    #1 chk({31'b0, flag_word[3]}, 32'd1, "busy with queued byte");
    @(negedge clk);
    tag = "R9";
    tx_out_ready = 1; step();
    tx_out_ready = 0; step(); step();
    tx_out_ready = 1; shift_done = 1; step();
    idle_in(); step();
    #1 chk({31'b0, flag_word[3]}, 32'd1, "busy kept on coincident load");
    @(negedge clk);
    shift_done = 1; step();
    idle_in(); step();
    #1 chk({31'b0, flag_word[3]}, 32'd0, "busy cleared after done");
    @(negedge clk);
    for (int i = 0; i < 200; i++) rand_cycle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule